// File: doc/BRIEF.md
# Shift-Permute Execution Unit

This unit is the shift and bit-rearrangement lane of a cryptographic RISC datapath. One opcode, two source words and an immediate go in, and one destination word comes out. The operations are left and right shifts, a sign-filling right shift, a 32-bit rotate, a two-word funnel shift and two bit-interleave operations. The interleaves square binary polynomials when one source is zero. A highest-set-bit count gives the degree of a polynomial. The funnel shift moves polynomials that span several words.

The word width `WIDTH` may be 32, 64 or 128. The 32-bit rotate keeps its meaning at every width, so hash code written for 32-bit words runs unchanged on a wider datapath. All arithmetic settles in one cycle. The parameter `OUT_REG` (default 1) places a result register at the output. With `OUT_REG` = 0 the output is combinational.

Top module: `shperm_unit`

## Requirements
- R1: While `rst_n` is low the registered `result` is 0.
- R2: With `OUT_REG` = 1, `result` shows the outcome of the operands present at a rising clock edge from that edge on, and holds its old value before the edge.
- R3: Opcode 0 shifts `src_a` left by `src_b[log2(WIDTH)-1:0]`. Opcode 1 shifts `src_a` left by `imm`. Vacated bits are zero.
- R4: Opcode 2 shifts `src_a` right by `src_b[log2(WIDTH)-1:0]`. Opcode 3 shifts `src_a` right by `imm`. Both fill with zeros.
- R5: Opcode 4 (amount from `src_b` low bits) and opcode 5 (amount from `imm`) shift `src_a` right and fill vacated bits with copies of `src_a[WIDTH-1]`.
- R6: Opcode 6 rotates `src_a[31:0]` left by `imm[4:0]`. Result bits above 31 are zero.
- R7: Opcode 7 forms `{src_a, src_b}` and shifts it right by `imm`. The result is the low `WIDTH` bits, so an `imm` of 0 returns `src_b`.
- R8: Opcode 8 (low interleave): for i < `WIDTH`/2, result bit 2i is `src_b[i]` and bit 2i+1 is `src_a[i]`. With `src_a` = 0, all odd result bits are zero.
- R9: Opcode 9 (high interleave) does the same as R8 with `src_b[WIDTH/2+i]` and `src_a[WIDTH/2+i]`.
- R10: Opcode 10 returns the index of the most significant set bit of `src_a` plus one, zero-extended. It returns 0 when `src_a` is 0.
- R11: Opcodes 11 to 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation select (R3 to R11) |
| src_a | input | WIDTH | First source operand |
| src_b | input | WIDTH | Second source operand |
| imm | input | log2(WIDTH) | Immediate shift or rotate amount |
| result | output | WIDTH | Destination word |

## Verification
With the default output register, every operation has the same timing. Operands set up before a rising edge appear on `result` just after that edge. Before the edge, `result` still shows the previous outcome. The bench changes the operands on a falling edge and reads `result` on the next falling edge, exactly one rising edge later. It also takes one sample shortly after it drives new operands, to show that the old value is still held. Expected values come from a bit-by-bit reference written in the bench, plus literal constants for the polynomial squaring and degree cases.

// File: rtl/shperm_pkg.sv
package shperm_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_SLL   = 4'd0,
    OP_SLLI  = 4'd1,
    OP_SRL   = 4'd2,
    OP_SRLI  = 4'd3,
    OP_SRA   = 4'd4,
    OP_SRAI  = 4'd5,
    OP_ROT32 = 4'd6,
    OP_FUNNEL= 4'd7,
    OP_MIXLO = 4'd8,
    OP_MIXHI = 4'd9,
    OP_DEGREE= 4'd10
  } shperm_op_e;

  // True when the shift amount comes from the second register operand.
  function automatic logic amt_from_reg(input logic [OPC_W-1:0] opc);
    return (opc == OP_SLL) || (opc == OP_SRL) || (opc == OP_SRA);
  endfunction

endpackage

// File: rtl/shperm_shifter.sv
module shperm_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SHW-1:0]   reg_amt,
  input  logic [SHW-1:0]   imm,
  input  logic             use_reg,
  output logic [WIDTH-1:0] sll_res,
  output logic [WIDTH-1:0] srl_res,
  output logic [WIDTH-1:0] sra_res,
  output logic [WIDTH-1:0] rot_res,
  output logic [WIDTH-1:0] fun_res
);

  // Rotate the low 32 bits left. The doubled copy avoids a second shifter.
  function automatic logic [31:0] rotl32(input logic [31:0] x, input logic [4:0] s);
    logic [63:0] dbl;
    dbl = {x, x} << s;
    return dbl[63:32];
  endfunction

  // Right shift of the concatenated pair, keeping the low word.
  function automatic logic [WIDTH-1:0] pair_shr(input logic [WIDTH-1:0] hi,
                                                 input logic [WIDTH-1:0] lo,
                                                 input logic [SHW-1:0] s);
    logic [2*WIDTH-1:0] cat;
    cat = {hi, lo} >> s;
    return cat[WIDTH-1:0];
  endfunction

  logic [SHW-1:0] amt;
  assign amt = use_reg ? reg_amt : imm;

  assign sll_res = a << amt;
  assign srl_res = a >> amt;
  assign sra_res = WIDTH'($signed(a) >>> amt);
  assign fun_res = pair_shr(a, b, imm);

  generate
    if (WIDTH > 32) begin : g_wide_rot
      assign rot_res = {{(WIDTH-32){1'b0}}, rotl32(a[31:0], imm[4:0])};
    end else begin : g_narrow_rot
      assign rot_res = rotl32(a[31:0], imm[4:0]);
    end
  endgenerate

endmodule

// File: rtl/shperm_shuffle.sv
module shperm_shuffle #(
  parameter int WIDTH = 32,
  localparam int HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] lo_res,
  output logic [WIDTH-1:0] hi_res
);

  generate
    for (genvar i = 0; i < HALF; i++) begin : g_pair
      assign lo_res[2*i]   = b[i];
      assign lo_res[2*i+1] = a[i];
      assign hi_res[2*i]   = b[HALF+i];
      assign hi_res[2*i+1] = a[HALF+i];
    end
  endgenerate

endmodule

// File: rtl/shperm_degree.sv
module shperm_degree #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] a,
  output logic [CW-1:0]    cnt
);

  // Position of the top set bit plus one; zero for an all-zero word.
  function automatic logic [CW-1:0] top_plus_one(input logic [WIDTH-1:0] x);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (x[i]) r = CW'(i + 1);
    end
    return r;
  endfunction

  assign cnt = top_plus_one(a);

endmodule

// File: rtl/shperm_unit.sv
module shperm_unit
  import shperm_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int SHW = $clog2(WIDTH),
  localparam int CW  = SHW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [SHW-1:0]   imm,
  output logic [WIDTH-1:0] result
);

  function automatic logic [WIDTH-1:0] odd_mask();
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 1; i < WIDTH; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [WIDTH-1:0] ODD_BITS = odd_mask();

  logic [WIDTH-1:0] sll_w, srl_w, sra_w, rot_w, fun_w, mixlo_w, mixhi_w;
  logic [CW-1:0]    deg_w;
  logic [WIDTH-1:0] result_d;
  shperm_op_e       op_e;

  assign op_e = shperm_op_e'(opcode);

  shperm_shifter #(.WIDTH(WIDTH)) u_shift (
    .a(src_a), .b(src_b), .reg_amt(src_b[SHW-1:0]), .imm(imm),
    .use_reg(amt_from_reg(opcode)),
    .sll_res(sll_w), .srl_res(srl_w), .sra_res(sra_w),
    .rot_res(rot_w), .fun_res(fun_w)
  );

  shperm_shuffle #(.WIDTH(WIDTH)) u_mix (
    .a(src_a), .b(src_b), .lo_res(mixlo_w), .hi_res(mixhi_w)
  );

  shperm_degree #(.WIDTH(WIDTH)) u_deg (
    .a(src_a), .cnt(deg_w)
  );

  always_comb begin
    unique case (op_e)
      OP_SLL, OP_SLLI:  result_d = sll_w;
      OP_SRL, OP_SRLI:  result_d = srl_w;
      OP_SRA, OP_SRAI:  result_d = sra_w;
      OP_ROT32:         result_d = rot_w;
      OP_FUNNEL:        result_d = fun_w;
      OP_MIXLO:         result_d = mixlo_w;
      OP_MIXHI:         result_d = mixhi_w;
      OP_DEGREE:        result_d = {{(WIDTH-CW){1'b0}}, deg_w};
      default:          result_d = '0;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [WIDTH-1:0] result_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result_q <= '0;
        else        result_q <= result_d;
      end
      assign result = result_q;

      // The registered output carries the previous cycle's combinational value.
      assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> result_q == $past(result_d));
    end else begin : g_comb
      assign result = result_d;
    end
  endgenerate

  // Degree count: zero only for an all-zero source.
  assert_degree_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (deg_w == '0) |-> (src_a == '0));

  // Degree count: the indicated bit is set and nothing above it is.
  assert_degree_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (deg_w != '0) |-> ((src_a >> (deg_w - CW'(1))) == WIDTH'(1)));

  // Interleaving with a zero first source leaves every odd bit clear.
  assert_mix_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0) |-> ((mixlo_w & ODD_BITS) == '0));

  // A rotate keeps the population of the low 32 bits.
  assert_rot_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rot_w) == $countones(src_a[31:0]));

  // A negative operand stays negative under the sign-filling shift.
  assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_a[WIDTH-1] |-> sra_w[WIDTH-1]);

endmodule

// File: tb/test_shperm_unit.sv
module test_shperm_unit;

  localparam int W = 32;
  localparam int SHW = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     opcode = 4'd0;
  logic [W-1:0]   src_a = '0;
  logic [W-1:0]   src_b = '0;
  logic [SHW-1:0] imm = '0;
  logic [W-1:0]   result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  shperm_unit #(.WIDTH(W), .OUT_REG(1'b1)) i_shperm_unit (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .imm(imm), .result(result)
  );

  // Bitwise reference, written independently of the RTL.
  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [SHW-1:0] im);
    logic [W-1:0] r;
    int s;
    r = '0;
    s = (op == 0 || op == 2 || op == 4) ? int'(b[SHW-1:0]) : int'(im);
    case (op)
      4'd0, 4'd1: for (int i = 0; i < W; i++) r[i] = (i >= s) ? a[i-s] : 1'b0;
      4'd2, 4'd3: for (int i = 0; i < W; i++) r[i] = (i + s < W) ? a[i+s] : 1'b0;
      4'd4, 4'd5: for (int i = 0; i < W; i++) r[i] = (i + s < W) ? a[i+s] : a[W-1];
      4'd6: for (int i = 0; i < 32; i++) r[(i + int'(im)) % 32] = a[i];
      4'd7: for (int i = 0; i < W; i++) r[i] = (i + s < W) ? b[i+s] : a[i+s-W];
      4'd8: for (int i = 0; i < W/2; i++) begin r[2*i] = b[i]; r[2*i+1] = a[i]; end
      4'd9: for (int i = 0; i < W/2; i++) begin r[2*i] = b[W/2+i]; r[2*i+1] = a[W/2+i]; end
      4'd10: for (int i = 0; i < W; i++) if (a[i]) r = W'(i + 1);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive on a falling edge, read one rising edge later.
  task automatic run_op(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [SHW-1:0] im);
    @(negedge clk);
    opcode = op; src_a = a; src_b = b; imm = im;
    @(negedge clk);
    check(tag, result, model(op, a, b, im));
  endtask

  task automatic t_reset();
    opcode = 4'd1; src_a = 32'hFFFF_FFFF; imm = 5'd3;
    repeat (3) @(negedge clk);
    check("R1 reset", result, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency();
    run_op("R2 first", 4'd1, 32'h0000_00F0, '0, 5'd4);
    @(negedge clk);
    opcode = 4'd3; src_a = 32'h8000_0000; imm = 5'd31;
    #2;
    check("R2 hold before edge", result, 32'h0000_0F00);
    @(negedge clk);
    check("R2 after edge", result, 32'h0000_0001);
  endtask

  task automatic t_left();
    run_op("R3 sll reg", 4'd0, 32'h1234_5678, 32'hFFFF_FFE8, 5'd0);
    run_op("R3 slli", 4'd1, 32'hDEAD_BEEF, '0, 5'd31);
    run_op("R3 slli zero", 4'd1, 32'hA5A5_A5A5, '0, 5'd0);
  endtask

  task automatic t_right();
    run_op("R4 srl reg", 4'd2, 32'hF000_000F, 32'h0000_0044, 5'd0);
    run_op("R4 srli", 4'd3, 32'h8765_4321, '0, 5'd12);
    check("R4 zero fill", result, 32'h0008_7654);
  endtask

  task automatic t_arith();
    run_op("R5 sra reg", 4'd4, 32'h8000_0010, 32'd4, 5'd0);
    check("R5 sign fill", result, 32'hF800_0001);
    run_op("R5 srai pos", 4'd5, 32'h7FFF_0000, '0, 5'd16);
    run_op("R5 srai max", 4'd5, 32'h9000_0000, '0, 5'd31);
  endtask

  task automatic t_rotate();
    run_op("R6 rot", 4'd6, 32'h8000_0001, '0, 5'd1);
    check("R6 rot value", result, 32'h0000_0003);
    run_op("R6 rot 31", 4'd6, 32'h1234_5678, '0, 5'd31);
  endtask

  task automatic t_funnel();
    run_op("R7 funnel imm0", 4'd7, 32'hAAAA_AAAA, 32'h1357_9BDF, 5'd0);
    check("R7 returns src_b", result, 32'h1357_9BDF);
    run_op("R7 funnel 8", 4'd7, 32'h0000_00CD, 32'h1122_3344, 5'd8);
    check("R7 value", result, 32'hCD11_2233);
  endtask

  task automatic t_shuffle();
    run_op("R8 square", 4'd8, '0, 32'h0000_000D, 5'd0);
    check("R8 square value", result, 32'h0000_0051);
    run_op("R8 mix", 4'd8, 32'h0000_FFFF, 32'h0000_0000, 5'd0);
    check("R8 odd bits", result, 32'hAAAA_AAAA);
    run_op("R9 mix high", 4'd9, 32'h8001_0000, 32'h0003_0000, 5'd0);
    check("R9 value", result, 32'h8000_0007);
  endtask

  task automatic t_degree();
    run_op("R10 zero", 4'd10, '0, '0, 5'd0);
    check("R10 zero value", result, '0);
    run_op("R10 one", 4'd10, 32'h0000_0001, '0, 5'd0);
    run_op("R10 top", 4'd10, 32'h8000_0000, '0, 5'd0);
    check("R10 top value", result, 32'd32);
    run_op("R10 mid", 4'd10, 32'h0000_1F00, 32'hFFFF_FFFF, 5'd0);
  endtask

  task automatic t_unused();
    for (int op = 11; op < 16; op++) begin
      run_op("R11 unused", 4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7);
      check("R11 zero", result, '0);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_left();
    t_right();
    t_arith();
    t_rotate();
    t_funnel();
    t_shuffle();
    t_degree();
    t_unused();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule